// File: doc/BRIEF.md
# Shared-SRAM Multi-Queue Manager

This block runs a small set of word-wide hardware queues, each kept as a circular buffer inside one shared single-port SRAM. Software reaches everything through a simple synchronous register bus. Each queue has an access address and a configuration word. A write to the access address pushes a word, and a read from it pops one. The configuration word places the queue in the SRAM and also exposes the queue's live write and read pointers.

Each queue is given its own slice of the SRAM through a base field, counted in 16-word units, and a buffer-size code. A pop from an empty queue returns zero. A push to a full queue is dropped. Both events set sticky per-queue flags, and software clears these by writing the flag register back with the chosen bits at zero. A status register reports, for every queue, empty, full and two watermark conditions.

Reads return data on the cycle after the request, marked by a one-cycle valid pulse. Writes take effect at the request edge.

Top module: `sram_queue_mgr`

## Requirements
- R1: After reset, every configuration word reads zero, the flag register (word address 16) reads zero, and every queue is empty. With 8 queues the status register (word address 17) therefore reads 0x33333333.
- R2: Configuration words sit at word addresses 8+q. Their layout is: bits [6:0] write pointer, [13:7] read pointer, [15:14] entry size, [17:16] buffer-size code, [20:18] nearly-empty code, [23:21] nearly-full code, [31:24] base in 16-word units. Writing a configuration word loads the size, watermark and base fields and clears both pointers, so the queue becomes empty. The entry-size field always reads 00 (one word per entry).
- R3: A write to word address q (q below the queue count) pushes the data onto queue q. A read from that address pops words in first-in first-out order. Every bus read returns its data, with bus_rvalid high, on the cycle after the request.
- R4: A pop from an empty queue returns 0, sets underflow flag bit q of the flag register, and leaves both pointers unchanged.
- R5: A queue holds at most size-1 words. A push to a full queue is discarded, sets overflow flag bit 8+q, and leaves both pointers unchanged.
- R6: Flags are sticky. A write to the flag register can only clear bits: each flag becomes its old value AND the written bit.
- R7: The buffer-size code c gives a buffer of 16<<c words. Pointers advance modulo the buffer size, and the SRAM word used is base*16 plus the pointer.
- R8: Status bits [4q+3:4q] for queue q are {full, nearly full, nearly empty, empty}. A watermark code k means a threshold of 0 when k is 0, and 2^(k-1) otherwise. Nearly empty means occupancy is at or below the nearly-empty threshold. Nearly full means free space (size-1 minus occupancy) is at or below the nearly-full threshold.
- R9: Queues are independent. An operation on one queue leaves every other queue's contents, pointers and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (5 bits for 8 queues) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after a read request |

## Verification
The embedded assertions watch the behaviour that can be judged from one cycle to the next. They check that a dropped push leaves the write pointer alone, that an empty pop raises the underflow flag, that flags persist unless a write clears them, and that pointers stay inside the configured buffer. They also check that an accepted push raises occupancy by exactly one, and that every read request gets a response on the next cycle. Only the directed scenarios can show end-to-end correctness: data returning in order across a pointer wrap, the exact field layout read back from the configuration word, watermark transitions at their threshold occupancies, and isolation between queues that share the SRAM.

// File: rtl/qmgr_pkg.sv
// Package: field layout of the queue configuration word plus small
// decode helpers shared by the per-queue slot and the top.
package qmgr_pkg;
    localparam int CFG_W   = 32;
    localparam int PTR_W   = 7;
    localparam int BASE_W  = 8;
    localparam int WP_LSB  = 0;
    localparam int RP_LSB  = 7;
    localparam int ES_LSB  = 14;
    localparam int BS_LSB  = 16;
    localparam int NE_LSB  = 18;
    localparam int NF_LSB  = 21;
    localparam int BA_LSB  = 24;

    // Pointer mask for a buffer-size code: 16, 32, 64 or 128 words.
    function automatic logic [PTR_W-1:0] size_mask(input logic [1:0] code);
        return {code == 2'd3, code >= 2'd2, code >= 2'd1, 4'hF};
    endfunction

    // Threshold for a 3-bit watermark code: 0, 1, 2, 4, ... 64.
    function automatic logic [PTR_W:0] wm_threshold(input logic [2:0] code);
        return (code == 3'd0) ? '0 : (PTR_W+1)'(1) << (code - 3'd1);
    endfunction
endpackage

// File: rtl/qmgr_sram.sv
// Module: single-port synchronous SRAM model. One access per cycle;
// read data appears the cycle after a read. Assumes no reset of contents.
module qmgr_sram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [2**AW];

    // Write or read the addressed word on an enabled cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/qmgr_qslot.sv
// Module: state of one queue. Holds the config fields, the live pointers
// and the sticky flags, and derives occupancy, status and SRAM addresses.
// Assumes at most one of cfg_we, push, pop, flag_we is active per cycle.
module qmgr_qslot
    import qmgr_pkg::*;
#(
    parameter int SRAM_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               push,
    input  logic               pop,
    input  logic               flag_we,
    input  logic               keep_uf,
    input  logic               keep_of,
    output logic [CFG_W-1:0]   cfg_word,
    output logic [SRAM_AW-1:0] wr_addr,
    output logic [SRAM_AW-1:0] rd_addr,
    output logic               empty,
    output logic               full,
    output logic               near_empty,
    output logic               near_full,
    output logic               uf_flag,
    output logic               of_flag
);
    localparam int SUM_W = BASE_W + 4;

    logic [1:0]        bsize_q;
    logic [2:0]        ne_q, nf_q;
    logic [BASE_W-1:0] base_q;
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [PTR_W-1:0]  mask, occ, free_sp;
    logic [SUM_W-1:0]  wr_sum, rd_sum;
    logic              push_ok, pop_ok;
    logic              unused_bits;

    assign unused_bits = ^{cfg_wdata[ES_LSB+1:0]};

    // Occupancy, watermarks and acceptance of this cycle's operation.
    always_comb begin
        mask       = size_mask(bsize_q);
        occ        = (wp_q - rp_q) & mask;
        free_sp    = mask - occ;
        empty      = (occ == '0);
        full       = (occ == mask);
        near_empty = {1'b0, occ} <= wm_threshold(ne_q);
        near_full  = {1'b0, free_sp} <= wm_threshold(nf_q);
        push_ok    = push && !full;
        pop_ok     = pop && !empty;
    end

    // SRAM word for the next push and the next pop.
    always_comb begin
        wr_sum  = {base_q, 4'b0000} + SUM_W'(wp_q & mask);
        rd_sum  = {base_q, 4'b0000} + SUM_W'(rp_q & mask);
        wr_addr = SRAM_AW'(wr_sum);
        rd_addr = SRAM_AW'(rd_sum);
    end

    assign cfg_word = {base_q, nf_q, ne_q, bsize_q, 2'b00, rp_q, wp_q};

    // Config load and pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsize_q <= '0; ne_q <= '0; nf_q <= '0; base_q <= '0;
            wp_q    <= '0; rp_q <= '0;
        end else if (cfg_we) begin
            bsize_q <= cfg_wdata[BS_LSB +: 2];
            ne_q    <= cfg_wdata[NE_LSB +: 3];
            nf_q    <= cfg_wdata[NF_LSB +: 3];
            base_q  <= cfg_wdata[BA_LSB +: BASE_W];
            wp_q    <= '0;
            rp_q    <= '0;
        end else begin
            if (push_ok) wp_q <= (wp_q + 1'b1) & mask;
            if (pop_ok)  rp_q <= (rp_q + 1'b1) & mask;
        end
    end

    // Sticky underflow/overflow flags; software writes can only clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_flag <= 1'b0;
            of_flag <= 1'b0;
        end else begin
            uf_flag <= (pop && empty)  || (uf_flag && !(flag_we && !keep_uf));
            of_flag <= (push && full)  || (of_flag && !(flag_we && !keep_of));
        end
    end

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !cfg_we) |=> $stable(wp_q));
    a_r4_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !cfg_we) |=> (uf_flag && $stable(rp_q)));
    a_r6_sticky_uf: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !(flag_we && !keep_uf)) |=> uf_flag);
    a_r6_sticky_of: assert property (@(posedge clk) disable iff (!rst_n)
        (of_flag && !(flag_we && !keep_of)) |=> of_flag);
    a_r7_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((wp_q | rp_q) & ~mask) == '0);
    a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !cfg_we) |=> occ == (($past(occ) + 1'b1) & mask));
endmodule

// File: rtl/sram_queue_mgr.sv
// Module: top of the queue manager. Decodes the register bus into
// per-queue push, pop and config strobes, shares one SRAM port among the
// queues and returns read data one cycle after the request.
// Assumes NUM_Q is a power of two and 4*NUM_Q fits in 32 bits.
module sram_queue_mgr
    import qmgr_pkg::*;
#(
    parameter int NUM_Q   = 8,
    parameter int SRAM_AW = 8,
    localparam int QW     = $clog2(NUM_Q),
    localparam int ADDR_W = QW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CFG_W-1:0]  bus_wdata,
    output logic [CFG_W-1:0]  bus_rdata,
    output logic              bus_rvalid
);
    localparam logic [1:0] RG_ACC = 2'd0;
    localparam logic [1:0] RG_CFG = 2'd1;
    localparam logic [1:0] RG_MSC = 2'd2;

    logic [1:0]         region;
    logic [QW-1:0]      qsel;
    logic               acc_wr, acc_rd, flag_we;
    logic [NUM_Q-1:0]   push_v, pop_v, cfg_v;
    logic [NUM_Q-1:0]   empty_v, full_v, ne_v, nf_v, uf_v, of_v;
    logic [CFG_W-1:0]   cfg_a   [NUM_Q];
    logic [SRAM_AW-1:0] wra_a   [NUM_Q];
    logic [SRAM_AW-1:0] rda_a   [NUM_Q];
    logic [CFG_W-1:0]   flag_word, stat_word, hold_d, hold_q, sram_q;
    logic               sram_en, sram_we, from_sram_q;
    logic [SRAM_AW-1:0] sram_addr;

    // Bus decode into region, queue select and operation strobes.
    always_comb begin
        region  = bus_addr[ADDR_W-1 -: 2];
        qsel    = bus_addr[QW-1:0];
        acc_wr  = bus_sel && bus_we  && region == RG_ACC;
        acc_rd  = bus_sel && !bus_we && region == RG_ACC;
        flag_we = bus_sel && bus_we  && region == RG_MSC && !bus_addr[0];
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        assign push_v[q] = acc_wr && qsel == QW'(q);
        assign pop_v[q]  = acc_rd && qsel == QW'(q);
        assign cfg_v[q]  = bus_sel && bus_we && region == RG_CFG && qsel == QW'(q);

        qmgr_qslot #(.SRAM_AW(SRAM_AW)) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_v[q]),
            .cfg_wdata  (bus_wdata),
            .push       (push_v[q]),
            .pop        (pop_v[q]),
            .flag_we    (flag_we),
            .keep_uf    (bus_wdata[q]),
            .keep_of    (bus_wdata[NUM_Q+q]),
            .cfg_word   (cfg_a[q]),
            .wr_addr    (wra_a[q]),
            .rd_addr    (rda_a[q]),
            .empty      (empty_v[q]),
            .full       (full_v[q]),
            .near_empty (ne_v[q]),
            .near_full  (nf_v[q]),
            .uf_flag    (uf_v[q]),
            .of_flag    (of_v[q])
        );
    end

    // Pack flag and status words from the per-queue outputs.
    always_comb begin
        flag_word = '0;
        stat_word = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            flag_word[q]         = uf_v[q];
            flag_word[NUM_Q+q]   = of_v[q];
            stat_word[4*q +: 4]  = {full_v[q], nf_v[q], ne_v[q], empty_v[q]};
        end
    end

    // Single SRAM port: accepted push writes, accepted pop reads.
    always_comb begin
        sram_we   = acc_wr && !full_v[qsel];
        sram_en   = sram_we || (acc_rd && !empty_v[qsel]);
        sram_addr = acc_wr ? wra_a[qsel] : rda_a[qsel];
    end

    qmgr_sram #(.AW(SRAM_AW), .DW(CFG_W)) i_sram (
        .clk   (clk),
        .en    (sram_en),
        .we    (sram_we),
        .addr  (sram_addr),
        .wdata (bus_wdata),
        .rdata (sram_q)
    );

    // Register-side read value; an empty pop yields zero.
    always_comb begin
        case (region)
            RG_CFG:  hold_d = cfg_a[qsel];
            RG_MSC:  hold_d = bus_addr[0] ? stat_word : flag_word;
            default: hold_d = '0;
        endcase
    end

    // Read response pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid  <= 1'b0;
            from_sram_q <= 1'b0;
            hold_q      <= '0;
        end else begin
            bus_rvalid  <= bus_sel && !bus_we;
            from_sram_q <= acc_rd && !empty_v[qsel];
            hold_q      <= hold_d;
        end
    end

    assign bus_rdata = from_sram_q ? sram_q : hold_q;

    a_r3_read_response: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> bus_rvalid);
    a_r4_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && empty_v[qsel]) |=> (bus_rdata == '0));
    a_r9_one_queue_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_v | pop_v | cfg_v));
endmodule

// File: tb/test_sram_queue_mgr.sv
// Directed bench: one task per scenario, each checking its own results.
module test_sram_queue_mgr;
    localparam int NQ = 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    int            n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    sram_queue_mgr #(.NUM_Q(NQ), .SRAM_AW(8)) i_sram_queue_mgr (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

    function automatic logic [31:0] mk_cfg(input int base, bsz, ne, nf);
        return (32'(base) << 24) | (32'(nf) << 21) | (32'(ne) << 18) | (32'(bsz) << 16);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        n_chk++;
        if (bus_rvalid !== 1'b1) begin
            n_bad++;
            $display("FAIL R3 rvalid: actual %b expected 1", bus_rvalid);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(16, d); check("R1 flags", d, 32'h0);
        rd(17, d); check("R1 status", d, 32'h33333333);
        for (int q = 0; q < NQ; q++) begin
            rd(8 + q, d); check("R1 cfg", d, 32'h0);
        end
        rd(0, d); check("R1 empty pop", d, 32'h0);
        wr(16, 32'h0);
    endtask

    task automatic t_config_fifo();
        logic [31:0] d;
        wr(8, mk_cfg(1, 0, 2, 2) | 32'h0000_FFFF);
        rd(8, d); check("R2 cfg readback", d, 32'h01480000);
        wr(0, 32'hA1); wr(0, 32'hB2); wr(0, 32'hC3);
        rd(0, d); check("R3 pop1", d, 32'hA1);
        rd(0, d); check("R3 pop2", d, 32'hB2);
        rd(0, d); check("R3 pop3", d, 32'hC3);
        rd(8, d); check("R2 ptrs", d, 32'h01480183);
    endtask

    task automatic t_underflow();
        logic [31:0] d;
        rd(0, d);  check("R4 empty pop zero", d, 32'h0);
        rd(16, d); check("R4 uf flag", d, 32'h1);
        rd(8, d);  check("R4 ptrs unchanged", d, 32'h01480183);
        wr(16, 32'hFFFFFFFF);
        rd(16, d); check("R6 write cannot set", d, 32'h1);
        wr(16, 32'hFFFFFFFE);
        rd(16, d); check("R6 clear", d, 32'h0);
    endtask

    task automatic t_full_wrap();
        logic [31:0] d;
        wr(9, mk_cfg(2, 0, 0, 0));
        for (int i = 1; i <= 15; i++) wr(1, 32'h100 + i);
        rd(17, d); check("R8 full nibble", (d >> 4) & 32'hF, 32'hC);
        wr(1, 32'hDEAD);
        rd(16, d); check("R5 of flag", d, 32'h200);
        rd(9, d);  check("R5 ptrs unchanged", d, 32'h0200000F);
        for (int i = 1; i <= 15; i++) begin
            rd(1, d); check("R5 drain", d, 32'h100 + i);
        end
        rd(1, d);  check("R5 dropped word absent", d, 32'h0);
        wr(16, 32'h0);
        for (int i = 0; i < 3; i++) wr(1, 32'h300 + i);
        for (int i = 0; i < 3; i++) begin
            rd(1, d); check("R7 wrap data", d, 32'h300 + i);
        end
        rd(9, d);  check("R7 ptr wrap", d, 32'h02000102);
    endtask

    task automatic t_watermark();
        logic [31:0] d;
        wr(10, mk_cfg(4, 1, 3, 3));
        for (int i = 0; i < 4; i++) wr(2, 32'h200 + i);
        rd(17, d); check("R8 ne at 4", (d >> 8) & 32'hF, 32'h2);
        wr(2, 32'h204);
        rd(17, d); check("R8 ne off at 5", (d >> 8) & 32'hF, 32'h0);
        for (int i = 5; i < 27; i++) wr(2, 32'h200 + i);
        rd(17, d); check("R8 nf at 27", (d >> 8) & 32'hF, 32'h4);
        for (int i = 27; i < 31; i++) wr(2, 32'h200 + i);
        rd(17, d); check("R7 32-word full at 31", (d >> 8) & 32'hF, 32'hC);
        rd(2, d);  check("R7 32-word head", d, 32'h200);
        wr(10, mk_cfg(4, 1, 3, 3));
        rd(17, d); check("R2 cfg write empties", (d >> 8) & 32'hF, 32'h3);
        rd(2, d);  check("R2 pop after reconfig", d, 32'h0);
        wr(16, 32'h0);
    endtask

    task automatic t_independent();
        logic [31:0] d;
        wr(11, mk_cfg(6, 0, 0, 0));
        wr(12, mk_cfg(7, 0, 0, 0));
        wr(3, 32'hAA01); wr(4, 32'hBB01); wr(3, 32'hAA02);
        rd(4, d); check("R9 q4 head", d, 32'hBB01);
        rd(3, d); check("R9 q3 first", d, 32'hAA01);
        rd(3, d); check("R9 q3 second", d, 32'hAA02);
        rd(4, d); check("R9 q4 empty", d, 32'h0);
        rd(16, d); check("R9 only q4 flag", d, 32'h10);
        rd(9, d);  check("R9 q1 untouched", d, 32'h02000102);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config_fifo();
        t_underflow();
        t_full_wrap();
        t_watermark();
        t_independent();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule